// File: doc/BRIEF.md
# Speculative Store Gate Buffer

This block sits between a core running translated code and a single memory write port. Stores from the core go into a small circular queue and wait there until an external commit pulse declares them final. Committed entries then leave for memory one per cycle, oldest first. An external rollback pulse drops every store that has not yet been committed, so software can return to its last coherent checkpoint without any stray memory effects. Commit is meant to be pulsed once the emulated machine state is consistent, usually at each emulated instruction boundary.

Loads probe the queue combinationally. For each byte lane, the youngest valid entry with a matching address and an enabled byte supplies the data. Lanes with no such entry pass through the data that memory returned.

Three pointers track the queue: head (oldest entry), boundary (first uncommitted entry) and tail. A four-state controller summarises them. The states are EMPTY (nothing held), OPEN (only uncommitted entries), DRAIN (only committed entries) and MIXED (both kinds). A store moves EMPTY to OPEN and DRAIN to MIXED. A commit moves OPEN or MIXED to DRAIN. A rollback moves OPEN to EMPTY and MIXED to DRAIN. The last committed write leaving moves DRAIN to EMPTY and MIXED to OPEN. The write port is offered data only in DRAIN and MIXED.

Top module: `store_gate_buf`

## Requirements
- R1: After reset `st_stall`, `mem_wr_valid` and `ld_hit` are 0, and `ld_data` equals `ld_mem_data`.
- R2: An accepted store that has not been committed never appears on the write port, however long `mem_wr_ready` is high.
- R3: When DEPTH entries are held, `st_stall` is 1 and a store presented that cycle is dropped. Only the DEPTH held stores reach memory after a later commit.
- R4: A commit pulse makes every entry held before that cycle committed. A store accepted in the same cycle as the commit joins the next uncommitted group.
- R5: Committed entries are offered on `mem_wr_addr`, `mem_wr_data` and `mem_wr_be` oldest first. One leaves per cycle in which `mem_wr_valid` and `mem_wr_ready` are both 1. While ready is 0 the offered entry holds.
- R6: A rollback pulse discards every uncommitted entry and keeps the committed ones. A store accepted in the same cycle as the rollback is kept as a new uncommitted entry.
- R7: When commit and rollback are both 1 in a cycle, only the commit takes effect.
- R8: `ld_data` takes each byte lane b (bits 8b+7..8b) from the youngest held entry, committed or not, whose address equals `ld_addr` and whose byte-enable bit b is 1. Otherwise the lane comes from `ld_mem_data`. `ld_hit` is 1 when any lane was taken from the queue.
- R9: The controller state matches the pointers: `mem_wr_valid` is 1 exactly when at least one committed entry is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_stall | output | 1 | Queue full, store not taken |
| commit_i | input | 1 | Commit pulse |
| rollback_i | input | 1 | Rollback pulse |
| ld_addr | input | AW | Load probe address |
| ld_mem_data | input | DW | Data memory holds for ld_addr |
| ld_data | output | DW | Merged load data |
| ld_hit | output | 1 | Some lane came from the queue |
| mem_wr_valid | output | 1 | Committed entry offered |
| mem_wr_ready | input | 1 | Memory takes the offered entry |
| mem_wr_addr | output | AW | Offered address |
| mem_wr_data | output | DW | Offered data |
| mem_wr_be | output | DW/8 | Offered byte enables |

## Verification
Load forwarding and stall are combinational on the current queue, so the bench reads them in the same cycle it drives the probe, 1 ns after the falling edge. A store, commit or rollback changes the pointers at the next rising edge, so its effect on `mem_wr_valid`, the offered entry and forwarding is checked in the following cycle. A write counts as retired at the rising edge where valid and ready were both seen high. The bench keeps its own ordered model of held entries and a committed count, and updates them once per rising edge in the same order of events the requirements fix: drain, then commit or rollback, then the new store.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

    typedef enum logic [1:0] {
        GS_EMPTY = 2'd0,
        GS_OPEN  = 2'd1,
        GS_DRAIN = 2'd2,
        GS_MIXED = 2'd3
    } gs_state_t;

    function automatic gs_state_t gs_classify(input logic has_cmt, input logic has_unc);
        unique case ({has_cmt, has_unc})
            2'b00:   return GS_EMPTY;
            2'b01:   return GS_OPEN;
            2'b10:   return GS_DRAIN;
            default: return GS_MIXED;
        endcase
    endfunction

endpackage

// File: rtl/gsb_ctrl.sv
module gsb_ctrl
    import gsb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic          commit_i,
    input  logic          rollback_i,
    input  logic          wr_ready,
    output logic          st_stall,
    output logic          st_accept,
    output logic [PW-1:0] wr_idx,
    output logic [CW-1:0] head_ptr,
    output logic [CW-1:0] held_cnt,
    output logic          mem_wr_valid
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    gs_state_t     state_q, state_n;
    logic [CW-1:0] head_q, cmt_q, tail_q;
    logic [CW-1:0] head_n, cmt_n, tail_n, base_tail;
    logic [CW-1:0] cmt_cnt;
    logic          full, drain_fire, do_commit, do_rb;

    assign held_cnt = tail_q - head_q;
    assign cmt_cnt  = cmt_q - head_q;
    assign full     = (held_cnt == DEPTH_C);
    assign head_ptr = head_q;

    always_comb begin
        do_commit  = commit_i;
        do_rb      = rollback_i && !commit_i;
        st_stall   = full;
        st_accept  = st_valid && !full;
        drain_fire = mem_wr_valid && wr_ready;
        base_tail  = do_rb ? cmt_q : tail_q;
        wr_idx     = base_tail[PW-1:0];
        head_n     = head_q + CW'(drain_fire);
        cmt_n      = do_commit ? tail_q : cmt_q;
        tail_n     = base_tail + CW'(st_accept);
        state_n    = gs_classify((cmt_n != head_n), (tail_n != cmt_n));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_EMPTY;
            head_q  <= '0;
            cmt_q   <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_n;
            head_q  <= head_n;
            cmt_q   <= cmt_n;
            tail_q  <= tail_n;
        end
    end

    always_comb begin
        unique case (state_q)
            GS_EMPTY: mem_wr_valid = 1'b0;
            GS_OPEN:  mem_wr_valid = 1'b0;
            GS_DRAIN: mem_wr_valid = 1'b1;
            GS_MIXED: mem_wr_valid = 1'b1;
            default:  mem_wr_valid = 1'b0;
        endcase
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        held_cnt <= DEPTH_C);

    p_commit_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (tail_q - cmt_q) == CW'($past(st_accept)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !wr_ready) |=> (mem_wr_valid && head_q == $past(head_q)));

    p_rollback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback_i && !commit_i) |=> (tail_q - cmt_q) == CW'($past(st_accept)));

    p_commit_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && rollback_i) |=> cmt_q == $past(tail_q));

    p_state_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid == (cmt_cnt != '0));

endmodule

// File: rtl/gsb_store.sv
module gsb_store #(
    parameter int DEPTH = 4,
    parameter int AW = 8,
    parameter int DW = 32,
    localparam int BW = DW / 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [PW-1:0]              widx,
    input  logic [AW-1:0]              waddr,
    input  logic [DW-1:0]              wdata,
    input  logic [BW-1:0]              wbe,
    input  logic [PW-1:0]              ridx,
    output logic [AW-1:0]              rd_addr,
    output logic [DW-1:0]              rd_data,
    output logic [BW-1:0]              rd_be,
    output logic [DEPTH-1:0][AW-1:0]   ent_addr,
    output logic [DEPTH-1:0][DW-1:0]   ent_data,
    output logic [DEPTH-1:0][BW-1:0]   ent_be
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && widx == PW'(e)) begin
                ent_addr[e] <= waddr;
                ent_data[e] <= wdata;
                ent_be[e]   <= wbe;
            end
        end
    end

    assign rd_addr = ent_addr[ridx];
    assign rd_data = ent_data[ridx];
    assign rd_be   = ent_be[ridx];

endmodule

// File: rtl/gsb_fwd.sv
module gsb_fwd #(
    parameter int DEPTH = 4,
    parameter int AW = 8,
    parameter int DW = 32,
    localparam int BW = DW / 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic [CW-1:0]              head_ptr,
    input  logic [CW-1:0]              held_cnt,
    input  logic [DEPTH-1:0][AW-1:0]   ent_addr,
    input  logic [DEPTH-1:0][DW-1:0]   ent_data,
    input  logic [DEPTH-1:0][BW-1:0]   ent_be,
    input  logic [AW-1:0]              ld_addr,
    input  logic [DW-1:0]              ld_mem_data,
    output logic [DW-1:0]              ld_data,
    output logic                       ld_hit
);

    logic [BW-1:0] lane_hit;

    for (genvar b = 0; b < BW; b++) begin : g_lane
        always_comb begin
            logic [PW-1:0] idx;
            ld_data[b*8 +: 8] = ld_mem_data[b*8 +: 8];
            lane_hit[b] = 1'b0;
            for (int k = 0; k < DEPTH; k++) begin
                idx = head_ptr[PW-1:0] + PW'(k);
                if (CW'(k) < held_cnt && ent_addr[idx] == ld_addr && ent_be[idx][b]) begin
                    ld_data[b*8 +: 8] = ent_data[idx][b*8 +: 8];
                    lane_hit[b] = 1'b1;
                end
            end
        end
    end

    assign ld_hit = |lane_hit;

endmodule

// File: rtl/store_gate_buf.sv
module store_gate_buf #(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int DEPTH = 4,
    localparam int BW = DW / 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [BW-1:0] st_be,
    output logic          st_stall,
    input  logic          commit_i,
    input  logic          rollback_i,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_mem_data,
    output logic [DW-1:0] ld_data,
    output logic          ld_hit,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic [BW-1:0] mem_wr_be
);

    logic                     st_accept;
    logic [PW-1:0]            wr_idx;
    logic [CW-1:0]            head_ptr, held_cnt;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;
    logic [DEPTH-1:0][BW-1:0] ent_be;

    gsb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid),
        .commit_i(commit_i), .rollback_i(rollback_i), .wr_ready(mem_wr_ready),
        .st_stall(st_stall), .st_accept(st_accept), .wr_idx(wr_idx),
        .head_ptr(head_ptr), .held_cnt(held_cnt), .mem_wr_valid(mem_wr_valid)
    );

    gsb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk(clk), .we(st_accept), .widx(wr_idx),
        .waddr(st_addr), .wdata(st_data), .wbe(st_be),
        .ridx(head_ptr[PW-1:0]),
        .rd_addr(mem_wr_addr), .rd_data(mem_wr_data), .rd_be(mem_wr_be),
        .ent_addr(ent_addr), .ent_data(ent_data), .ent_be(ent_be)
    );

    gsb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .head_ptr(head_ptr), .held_cnt(held_cnt),
        .ent_addr(ent_addr), .ent_data(ent_data), .ent_be(ent_be),
        .ld_addr(ld_addr), .ld_mem_data(ld_mem_data),
        .ld_data(ld_data), .ld_hit(ld_hit)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!mem_wr_valid && !st_stall));

    p_no_early_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_valid) |=> $stable(head_ptr));

endmodule

// File: tb/store_gate_buf_tb.sv
module store_gate_buf_tb;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, commit_i = 1'b0, rollback_i = 1'b0, mem_wr_ready = 1'b0;
    logic [7:0]  st_addr = '0, ld_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic [31:0] ld_mem_data, ld_data, mem_wr_data;
    logic        st_stall, ld_hit, mem_wr_valid;
    logic [7:0]  mem_wr_addr;
    logic [3:0]  mem_wr_be;

    logic [31:0] mem [0:7];
    logic [7:0]  q_a [0:7];
    logic [31:0] q_d [0:7];
    logic [3:0]  q_b [0:7];
    int cnt = 0, ncm = 0, n_wr = 0;
    int checks = 0, failures = 0;
    logic [31:0] lfsr = 32'h1d872b41;

    always #2 clk = ~clk;

    assign ld_mem_data = mem[ld_addr[2:0]];

    store_gate_buf #(.AW(8), .DW(32), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
        .commit_i(commit_i), .rollback_i(rollback_i), .ld_addr(ld_addr),
        .ld_mem_data(ld_mem_data), .ld_data(ld_data), .ld_hit(ld_hit),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic sv, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic cm, input logic rb,
                        input logic rdy, input logic [7:0] la);
        logic        exp_full, exp_wv, exp_hit, fired;
        logic [31:0] exp_ld, wd;
        logic [7:0]  wa;
        logic [3:0]  wb;
        @(negedge clk);
        st_valid = sv; st_addr = a; st_data = d; st_be = be;
        commit_i = cm; rollback_i = rb; mem_wr_ready = rdy; ld_addr = la;
        #1;
        exp_full = (cnt == DEPTH);
        exp_wv = (ncm > 0);
        chk(st_stall == exp_full, "R3 stall", 32'(st_stall), 32'(exp_full));
        chk(mem_wr_valid == exp_wv, "R4 write valid", 32'(mem_wr_valid), 32'(exp_wv));
        if (exp_wv) begin
            chk(mem_wr_addr == q_a[0], "R5 write addr", 32'(mem_wr_addr), 32'(q_a[0]));
            chk(mem_wr_data == q_d[0], "R5 write data", mem_wr_data, q_d[0]);
            chk(mem_wr_be == q_b[0], "R5 write be", 32'(mem_wr_be), 32'(q_b[0]));
        end
        exp_ld = mem[la[2:0]];
        exp_hit = 1'b0;
        for (int i = 0; i < cnt; i++)
            if (q_a[i] == la)
                for (int b = 0; b < 4; b++)
                    if (q_b[i][b]) begin
                        exp_ld[b*8 +: 8] = q_d[i][b*8 +: 8];
                        exp_hit = 1'b1;
                    end
        chk(ld_data == exp_ld, "R8 load data", ld_data, exp_ld);
        chk(ld_hit == exp_hit, "R8 load hit", 32'(ld_hit), 32'(exp_hit));
        fired = mem_wr_valid && rdy;
        wa = mem_wr_addr; wd = mem_wr_data; wb = mem_wr_be;
        @(posedge clk);
        if (fired) begin
            for (int b = 0; b < 4; b++)
                if (wb[b]) mem[wa[2:0]][b*8 +: 8] = wd[b*8 +: 8];
            n_wr++;
        end
        if (exp_wv && rdy) begin
            for (int i = 0; i < 7; i++) begin
                q_a[i] = q_a[i+1]; q_d[i] = q_d[i+1]; q_b[i] = q_b[i+1];
            end
            cnt--; ncm--;
        end
        if (cm) ncm = cnt;
        else if (rb) cnt = ncm;
        if (sv && !exp_full) begin
            q_a[cnt] = a; q_d[cnt] = d; q_b[cnt] = be;
            cnt++;
        end
    endtask

    task automatic idle(input int n, input logic rdy);
        for (int i = 0; i < n; i++) step(1'b0, 8'h0, 32'h0, 4'h0, 1'b0, 1'b0, rdy, 8'(i % 4));
    endtask

    task automatic st(input logic [7:0] a, input logic [31:0] d, input logic cm, input logic rb, input logic rdy);
        step(1'b1, a, d, 4'hf, cm, rb, rdy, a);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        for (int i = 0; i < 8; i++) mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!st_stall, "R1 stall", 32'(st_stall), 0);
        chk(!mem_wr_valid, "R1 write valid", 32'(mem_wr_valid), 0);
        chk(!ld_hit, "R1 hit", 32'(ld_hit), 0);
        chk(ld_data == ld_mem_data, "R1 load", ld_data, ld_mem_data);

        // R2: uncommitted stores never reach memory
        base = n_wr;
        st(8'h1, 32'h11111111, 0, 0, 1);
        st(8'h2, 32'h22222222, 0, 0, 1);
        st(8'h1, 32'h33333333, 0, 0, 1);
        idle(5, 1);
        chk(n_wr == base, "R2 writes", 32'(n_wr), 32'(base));
        step(0, 0, 0, 0, 0, 1, 1, 8'h1);
        idle(2, 1);

        // R3: overfill then commit; only DEPTH writes
        base = n_wr;
        for (int i = 0; i < DEPTH + 2; i++) st(8'(i % 4), 32'hA0 + 32'(i), 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 8'h0);
        idle(8, 1);
        chk(n_wr == base + DEPTH, "R3 writes", 32'(n_wr), 32'(base + DEPTH));

        // R4: store in commit cycle joins next group
        base = n_wr;
        st(8'h2, 32'hB0, 0, 0, 0);
        st(8'h3, 32'hB1, 1, 0, 0);
        idle(6, 1);
        chk(n_wr == base + 1, "R4 writes", 32'(n_wr), 32'(base + 1));
        step(0, 0, 0, 0, 0, 1, 1, 8'h3);
        idle(3, 1);
        chk(n_wr == base + 1, "R4 after rollback", 32'(n_wr), 32'(base + 1));

        // R6: rollback keeps committed and same-cycle store
        base = n_wr;
        st(8'h0, 32'hC0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 8'h0);
        st(8'h0, 32'hC1, 0, 0, 0);
        st(8'h1, 32'hC2, 0, 1, 0);
        step(0, 0, 0, 0, 1, 0, 0, 8'h1);
        idle(6, 1);
        chk(n_wr == base + 2, "R6 writes", 32'(n_wr), 32'(base + 2));
        chk(mem[1] == 32'hC2, "R6 survivor", mem[1], 32'hC2);

        // R7: commit beats rollback
        base = n_wr;
        st(8'h2, 32'hD0, 0, 0, 0);
        st(8'h3, 32'hD1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 1, 0, 8'h2);
        idle(6, 1);
        chk(n_wr == base + 2, "R7 writes", 32'(n_wr), 32'(base + 2));

        // sweep: R5 ordering, R8 merging, R3 stall under mixed traffic
        for (int c = 0; c < 4000; c++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3:0] < 4'd10, {6'h0, lfsr[5:4]}, lfsr ^ 32'(c * 7919), lfsr[9:6],
                 lfsr[12:10] == 3'd0, lfsr[15:13] == 3'd0, lfsr[17:16] != 2'd0,
                 {6'h0, lfsr[19:18]});
        end
        idle(4, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule